// File: doc/BRIEF.md
# Converter-to-FIFO capture controller

This block lets a parallel 12-bit sampling converter fill a sample buffer without any processor involvement. It generates the converter's active-low start pulse on a programmable grid of system-clock cycles. It watches the converter's active-low busy line, and when that line returns high it writes the result word into an internal first-in first-out store. The processor empties that store later through a simple pop port.

Conversions are gated by three conditions. After reset the block waits out a power-up window, which is a fixed converter warm-up plus a programmable reference-settling time. After each finished conversion it leaves a minimum track gap. While the store is full it keeps the start line high, so that no sample is lost. A level interrupt asks the processor to drain a block once the store is at least half occupied. A sticky flag records any result that arrived while the store had no room, and a write-one input clears that flag.

Top module: `cap_ctrl`

## Requirements
- R1: While reset is low, `conv_start_n` is 1 and `fill_count`, `half_irq`, `fifo_full`, `overflow`, `rd_valid` and `rd_data` are all 0. Every stored word is also cleared, so no data from before the reset can be read afterwards.
- R2: The first falling edge of `conv_start_n` after reset comes no earlier than the posedge numbered W+1, where W = max(14*CONV_CLK_DIV + TRACK_CYC, `cfg_settle`). The first posedge after reset release is numbered 1, and that first start falls on the earliest grid slot that meets this bound.
- R3: Start slots lie on a grid whose first slot is posedge 1 and whose pitch is `cfg_period` cycles (a value of 0 means every cycle). A start is issued only at a slot. Each start drives `conv_start_n` low for exactly PULSE_CYC cycles.
- R4: At most one conversion is outstanding at a time. The posedge of a new start comes at least TRACK_CYC+1 cycles after the posedge that captured the previous result. When a slot falls too early, it is skipped.
- R5: A rising edge on `adc_busy_n` passes through a SYNC_STAGES synchronizer. With the default of 2, `adc_data` is stored at the third posedge after the edge. Words are stored unchanged (two's-complement code) and read back in arrival order.
- R6: A `pop` sampled while `fill_count` is nonzero puts the oldest word on `rd_data` and raises `rd_valid` for one cycle after that edge. A `pop` on an empty store leaves `rd_valid` at 0 and `fill_count` unchanged.
- R7: `half_irq` is 1 exactly while `fill_count` >= DEPTH/2.
- R8: `fifo_full` is 1 exactly while `fill_count` equals DEPTH. No falling edge of `conv_start_n` follows a cycle in which `fifo_full` was 1.
- R9: A captured result that finds the store full, judged by the count before any pop in the same cycle, is dropped and sets `overflow`. `overflow` stays 1 until `ovf_clr` is sampled high with no new drop in that cycle; a drop in the same cycle wins over the clear.
- R10: `fill_count` goes up by one for each stored word and down by one for each accepted pop. It never changes by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also clears the store |
| cfg_period | input | 16 | Start-slot pitch in clock cycles |
| cfg_settle | input | 20 | Reference-settling time in clock cycles, counted from reset |
| conv_start_n | output | 1 | Active-low start pulse to the converter |
| adc_busy_n | input | 1 | Converter busy line, low while a conversion runs |
| adc_data | input | 12 | Converter result word |
| pop | input | 1 | Read request for the oldest stored word |
| rd_data | output | 12 | Word returned by the last accepted pop |
| rd_valid | output | 1 | One-cycle strobe that `rd_data` is new |
| fill_count | output | 9 | Number of stored words |
| half_irq | output | 1 | Level interrupt, store at least half occupied |
| fifo_full | output | 1 | Store has no free entry |
| overflow | output | 1 | Sticky flag, a result was dropped |
| ovf_clr | input | 1 | Write-one clear of `overflow` |

## Verification
On every cycle the assertions enforce the local rules of the start line: no start while full, none before the power-up window or inside the track gap, and a minimum pulse width. They also check that the count moves by at most one, that a pop on an empty store stays silent, and that a result arriving on a full store sets the sticky flag and keeps it set. Other properties need whole scenarios and only the bench's scenarios show them. These are the exact slot of the first start for both a short and a long settling time, the skipped slot when the pitch is shorter than a conversion plus its track gap, the arrival order of 256 words through a fill-and-drain cycle with the interrupt falling at half occupancy, and the clearing of stored data by a reset.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int SAMPLE_W = 12;
    typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/cap_busy_edge.sv
module cap_busy_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_in,
    output logic done_pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    localparam edge_st_t EDGE_RST = '{sync: '1, prev: 1'b1};

    edge_st_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.sync = {e_q.sync[SYNC_STAGES-2:0], busy_n_in};
        e_d.prev = e_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= EDGE_RST;
        else        e_q <= e_d;
    end

    assign done_pulse = e_q.sync[SYNC_STAGES-1] & ~e_q.prev;

    // R5: a single synchronized edge yields exactly one capture strobe
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
endmodule

// File: rtl/cap_strobe_gen.sv
module cap_strobe_gen #(
    parameter int PERIOD_W     = 16,
    parameter int SETTLE_W     = 20,
    parameter int TRACK_CYC    = 44,
    parameter int CONV_CLK_DIV = 16,
    parameter int PWR_CLKS     = 14,
    parameter int PULSE_CYC    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [SETTLE_W-1:0] cfg_settle,
    input  logic                fifo_full,
    input  logic                done_pulse,
    output logic                start_n
);
    localparam int TRACK_W = $clog2(TRACK_CYC + 1);
    localparam int PULSE_W = $clog2(PULSE_CYC + 1);
    localparam logic [SETTLE_W-1:0] PWR_MIN_V = SETTLE_W'(PWR_CLKS * CONV_CLK_DIV + TRACK_CYC);
    localparam logic [TRACK_W-1:0]  TRACK_V   = TRACK_W'(TRACK_CYC);
    localparam logic [PULSE_W-1:0]  PULSE_V   = PULSE_W'(PULSE_CYC);

    typedef struct packed {
        logic [PERIOD_W-1:0] per;
        logic [SETTLE_W-1:0] pwr;
        logic [TRACK_W-1:0]  trk;
        logic                inflight;
        logic [PULSE_W-1:0]  low;
        logic                start_n;
    } gen_st_t;

    localparam gen_st_t GEN_RST = '{per: '0, pwr: '0, trk: '0, inflight: 1'b0,
                                    low: '0, start_n: 1'b1};

    gen_st_t g_d, g_q;
    logic tick, pwr_done, track_ok, fire;

    always_comb begin
        g_d      = g_q;
        tick     = (g_q.per == '0);
        pwr_done = (g_q.pwr >= PWR_MIN_V) && (g_q.pwr >= cfg_settle);
        track_ok = (g_q.trk >= TRACK_V);
        fire     = tick && pwr_done && track_ok && !g_q.inflight
                   && !fifo_full && (g_q.low == '0);

        if (tick) g_d.per = (cfg_period == '0) ? '0 : cfg_period - PERIOD_W'(1);
        else      g_d.per = g_q.per - PERIOD_W'(1);

        if (g_q.pwr != '1) g_d.pwr = g_q.pwr + SETTLE_W'(1);

        if (done_pulse)     g_d.trk = '0;
        else if (!track_ok) g_d.trk = g_q.trk + TRACK_W'(1);

        if (fire)            g_d.inflight = 1'b1;
        else if (done_pulse) g_d.inflight = 1'b0;

        if (fire)                g_d.low = PULSE_V;
        else if (g_q.low != '0)  g_d.low = g_q.low - PULSE_W'(1);

        g_d.start_n = (g_d.low == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= GEN_RST;
        else        g_q <= g_d;
    end

    assign start_n = g_q.start_n;

    // R8: a start never follows a cycle with the store full
    a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n) |-> $past(!fifo_full));

    // R2: no start before the power-up window has run out
    a_r2_settle_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n) |-> $past(pwr_done));

    // R4: a start keeps the track gap after the last capture
    a_r4_track_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n) |-> $past(track_ok));

    generate
        if (PULSE_CYC >= 2) begin : g_width_chk
            // R3: a start pulse lasts longer than one cycle
            a_r3_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(start_n) |=> !start_n);
        end
    endgenerate
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    input  logic                       ovf_clr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       half,
    output logic                       full,
    output logic                       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_V = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_V  = CW'(DEPTH / 2);
    localparam logic [AW-1:0] LAST_V  = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wp;
        logic [AW-1:0]                rp;
        logic [CW-1:0]                cnt;
        logic [DATA_W-1:0]            rdat;
        logic                         rvld;
        logic                         ovf;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic push_ok, pop_ok;

    always_comb begin
        f_d     = f_q;
        push_ok = push && (f_q.cnt != DEPTH_V);
        pop_ok  = pop && (f_q.cnt != '0);

        f_d.rvld = pop_ok;
        if (pop_ok) begin
            f_d.rdat = f_q.mem[f_q.rp];
            f_d.rp   = (f_q.rp == LAST_V) ? '0 : f_q.rp + AW'(1);
        end
        if (push_ok) begin
            f_d.mem[f_q.wp] = push_data;
            f_d.wp          = (f_q.wp == LAST_V) ? '0 : f_q.wp + AW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   f_d.cnt = f_q.cnt + CW'(1);
            2'b01:   f_d.cnt = f_q.cnt - CW'(1);
            default: f_d.cnt = f_q.cnt;
        endcase

        if (push && !push_ok) f_d.ovf = 1'b1;
        else if (ovf_clr)     f_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_data  = f_q.rdat;
    assign rd_valid = f_q.rvld;
    assign count    = f_q.cnt;
    assign half     = (f_q.cnt >= HALF_V);
    assign full     = (f_q.cnt == DEPTH_V);
    assign overflow = f_q.ovf;

    // R10: occupancy moves by at most one entry per cycle
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |->
        ((count == $past(count) + CW'(1)) || (count == $past(count) - CW'(1))));

    // R6: a pop on an empty store returns nothing
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0) |=> !rd_valid);

    // R9: a result arriving on a full store raises the sticky flag
    a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow);

    // R9: the flag holds until it is cleared
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl #(
    parameter int DEPTH        = 256,
    parameter int PERIOD_W     = 16,
    parameter int SETTLE_W     = 20,
    parameter int TRACK_CYC    = 44,
    parameter int CONV_CLK_DIV = 16,
    parameter int PWR_CLKS     = 14,
    parameter int PULSE_CYC    = 2,
    parameter int SYNC_STAGES  = 2,
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PERIOD_W-1:0]      cfg_period,
    input  logic [SETTLE_W-1:0]      cfg_settle,
    output logic                     conv_start_n,
    input  logic                     adc_busy_n,
    input  logic [cap_pkg::SAMPLE_W-1:0] adc_data,
    input  logic                     pop,
    output logic [cap_pkg::SAMPLE_W-1:0] rd_data,
    output logic                     rd_valid,
    output logic [CNT_W-1:0]         fill_count,
    output logic                     half_irq,
    output logic                     fifo_full,
    output logic                     overflow,
    input  logic                     ovf_clr
);
    logic done_pulse;

    cap_busy_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_n_in  (adc_busy_n),
        .done_pulse (done_pulse)
    );

    cap_strobe_gen #(
        .PERIOD_W     (PERIOD_W),
        .SETTLE_W     (SETTLE_W),
        .TRACK_CYC    (TRACK_CYC),
        .CONV_CLK_DIV (CONV_CLK_DIV),
        .PWR_CLKS     (PWR_CLKS),
        .PULSE_CYC    (PULSE_CYC)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .cfg_settle (cfg_settle),
        .fifo_full  (fifo_full),
        .done_pulse (done_pulse),
        .start_n    (conv_start_n)
    );

    cap_fifo #(.DATA_W(cap_pkg::SAMPLE_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (done_pulse),
        .push_data (adc_data),
        .pop       (pop),
        .ovf_clr   (ovf_clr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .count     (fill_count),
        .half      (half_irq),
        .full      (fifo_full),
        .overflow  (overflow)
    );

    // R7: the interrupt is raised only once at least half occupancy is reached
    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq |-> (fill_count >= CNT_W'(DEPTH / 2)));
endmodule

// File: tb/cap_ctrl_tb_top.sv
module cap_ctrl_tb_top;
    localparam int DEPTH    = 256;
    localparam int TRACK    = 44;
    localparam int PWR_MIN  = 14 * 16 + 44;
    localparam int PULSE    = 2;
    localparam int CONV_CYC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd100;
    logic [19:0] cfg_settle = 20'd0;
    logic        conv_start_n;
    logic        adc_busy_n = 1'b1;
    logic [11:0] adc_data = 12'd0;
    logic        pop = 1'b0;
    logic [11:0] rd_data;
    logic        rd_valid;
    logic [8:0]  fill_count;
    logic        half_irq, fifo_full, overflow;
    logic        ovf_clr = 1'b0;

    cap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_settle(cfg_settle),
        .conv_start_n(conv_start_n), .adc_busy_n(adc_busy_n), .adc_data(adc_data),
        .pop(pop), .rd_data(rd_data), .rd_valid(rd_valid), .fill_count(fill_count),
        .half_irq(half_irq), .fifo_full(fifo_full), .overflow(overflow), .ovf_clr(ovf_clr)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int q[$];
    int m_rd_data, m_rd_valid, m_ovf;
    int pipe_v[2], pipe_d[2];
    int cyc, last_push, last_fall, first_fall, fall_cnt, low_run, last_gap;
    int conv_left, busy_drv, sample_k, prev_start_n, prev_full, spacing_on;
    int pop_req, clr_req, inject_req, start_req, cur_period, cur_w;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int samp(input int k);
        case (k % 4)
            0:       return 12'h800;
            1:       return 12'h7FF;
            2:       return 0;
            default: return (k * 613 + 91) & 12'hFFF;
        endcase
    endfunction

    task automatic step();
        bit rise;
        bit push_now;
        int push_dat, old_cnt;
        rise = 0;
        pop = pop_req[0];
        ovf_clr = clr_req[0];
        if (conv_left > 0) begin
            conv_left--;
            if (conv_left == 0) begin
                busy_drv = 1;
                adc_data = 12'(samp(sample_k));
                sample_k++;
                rise = 1;
            end
        end else if (start_req != 0 || inject_req != 0) begin
            busy_drv = 0;
            conv_left = CONV_CYC;
        end
        start_req = 0;
        inject_req = 0;
        adc_busy_n = busy_drv[0];
        // model of the coming edge
        push_now = pipe_v[1][0];
        push_dat = pipe_d[1];
        pipe_v[1] = pipe_v[0]; pipe_d[1] = pipe_d[0];
        pipe_v[0] = rise;      pipe_d[0] = adc_data;
        old_cnt = q.size();
        if (pop_req != 0 && old_cnt > 0) begin
            m_rd_data = q.pop_front();
            m_rd_valid = 1;
        end else m_rd_valid = 0;
        if (push_now) begin
            if (old_cnt < DEPTH) q.push_back(push_dat);
            last_push = cyc + 1;
        end
        if (push_now && old_cnt == DEPTH) m_ovf = 1;
        else if (clr_req != 0) m_ovf = 0;
        @(negedge clk);
        cyc++;
        chk(fill_count == q.size(), "R10 fill_count", fill_count, q.size());
        chk(half_irq == (q.size() >= DEPTH / 2), "R7 half_irq", half_irq, q.size() >= DEPTH / 2);
        chk(fifo_full == (q.size() == DEPTH), "R8 fifo_full", fifo_full, q.size() == DEPTH);
        chk(overflow == m_ovf[0], "R9 overflow", overflow, m_ovf);
        chk(rd_valid == m_rd_valid[0], "R6 rd_valid", rd_valid, m_rd_valid);
        if (m_rd_valid != 0) chk(rd_data == 12'(m_rd_data), "R5 rd_data order", rd_data, m_rd_data);
        if (prev_start_n != 0 && !conv_start_n) begin
            fall_cnt++;
            start_req = 1;
            chk(prev_full == 0, "R8 start while full", 1, 0);
            chk(cyc >= cur_w + 1, "R2 start before power-up window", cyc, cur_w + 1);
            if (last_push > 0)
                chk(cyc - last_push >= TRACK + 1, "R4 track gap", cyc - last_push, TRACK + 1);
            if (first_fall == 0) first_fall = cyc;
            if (last_fall > 0) begin
                last_gap = cyc - last_fall;
                chk(last_gap % cur_period == 0, "R3 slot grid", last_gap, cur_period);
                if (spacing_on != 0) chk(last_gap == cur_period, "R3 pitch", last_gap, cur_period);
            end
            last_fall = cyc;
        end
        if (!conv_start_n) low_run++;
        else if (low_run != 0) begin
            chk(low_run == PULSE, "R3 pulse width", low_run, PULSE);
            low_run = 0;
        end
        prev_start_n = conv_start_n;
        prev_full = (q.size() == DEPTH);
    endtask

    task automatic do_reset(input int p, input int s);
        rst_n = 1'b0;
        cfg_period = 16'(p);
        cfg_settle = 20'(s);
        pop = 1'b0; ovf_clr = 1'b0; adc_busy_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(conv_start_n == 1'b1, "R1 start idle", conv_start_n, 1);
        chk(fill_count == 0 && !half_irq && !fifo_full, "R1 flags clear", fill_count, 0);
        chk(!overflow && !rd_valid, "R1 overflow/valid clear", overflow, 0);
        chk(rd_data == 12'd0, "R1 read word cleared", rd_data, 0);
        q.delete();
        m_rd_data = 0; m_rd_valid = 0; m_ovf = 0;
        pipe_v = '{0, 0}; pipe_d = '{0, 0};
        cyc = 0; last_push = 0; last_fall = 0; first_fall = 0; fall_cnt = 0;
        low_run = 0; last_gap = 0; conv_left = 0; busy_drv = 1;
        prev_start_n = 1; prev_full = 0;
        pop_req = 0; clr_req = 0; inject_req = 0; start_req = 0;
        cur_period = p;
        cur_w = (s > PWR_MIN) ? s : PWR_MIN;
        rst_n = 1'b1;
    endtask

    function automatic int first_slot(input int p, input int w);
        int e = 1;
        while (e - 1 < w) e += p;
        return e;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int guard, base;
        sample_k = 0;
        // Phase A: fill to full with a short settling time
        do_reset(100, 100);
        spacing_on = 1;
        guard = 0;
        while (q.size() < DEPTH && guard < 40000) begin step(); guard++; end
        chk(first_fall == first_slot(100, PWR_MIN), "R2 first start slot", first_fall, first_slot(100, PWR_MIN));
        chk(fifo_full && half_irq, "R8 full and R7 irq at capacity", fill_count, DEPTH);
        spacing_on = 0;
        base = fall_cnt;
        repeat (300) step();
        chk(fall_cnt == base, "R8 no start while full", fall_cnt - base, 0);
        // result arriving with no room
        inject_req = 1;
        repeat (40) step();
        chk(overflow == 1'b1 && fill_count == 9'(DEPTH), "R9 drop and flag", overflow, 1);
        repeat (5) step();
        chk(overflow == 1'b1, "R9 flag sticky", overflow, 1);
        clr_req = 1; step(); clr_req = 0;
        chk(overflow == 1'b0, "R9 write-one clear", overflow, 0);
        // drain in order, then pop on empty
        pop_req = 1;
        repeat (320) step();
        pop_req = 0;
        step();
        chk(!half_irq && fill_count < 9'd8, "R7 irq low after drain", fill_count, 0);
        while (q.size() != 0) begin pop_req = 1; step(); end
        pop_req = 1; step();
        chk(rd_valid == 1'b0 && fill_count == 9'd0, "R6 pop on empty ignored", rd_valid, 0);
        pop_req = 0;
        // Phase B: long settling time, new pitch; reset clears read word
        do_reset(150, 500);
        spacing_on = 1;
        guard = 0;
        while (q.size() < 6 && guard < 3000) begin step(); guard++; end
        chk(first_fall == first_slot(150, 500), "R2 settle-bound first start", first_fall, first_slot(150, 500));
        chk(q.size() == 6, "R5 samples captured", q.size(), 6);
        pop_req = 1; repeat (8) step(); pop_req = 0;
        // Phase C: pitch shorter than conversion plus track gap
        do_reset(40, 0);
        spacing_on = 0;
        repeat (1500) step();
        chk(first_fall == first_slot(40, PWR_MIN), "R3 first slot short pitch", first_fall, first_slot(40, PWR_MIN));
        chk(last_gap == 80, "R4 skipped slot", last_gap, 80);
        chk(fall_cnt > 10, "R4 conversions continue", fall_cnt, 11);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule